// File: doc/BRIEF.md
# Auto-Reload Toggle PWM Timer

This block turns a 32-bit up-counter into a pulse-width-modulated output. The counter runs up to all-ones, then reloads a programmed start value. The output comes from a toggle flip-flop. That flip-flop flips on every wrap of the counter and on every cycle in which the counter equals a programmed compare value. The wrap begins the active part of the waveform and the compare hit ends it. Software sets the reload value, the compare value, a clock divider, the output polarity and run/stop through a small write-only register port.

A start presets the counter to all-ones minus one, so the first active edge appears two counter ticks after the start. A stop clears the toggle flip-flop, which places the pin at its inactive level with polarity applied. The reload and compare registers are protected while the timer runs. A write to either of them during a run is dropped and sets a sticky error flag.

Top module: `reload_pwm`

## Requirements
- R1: After reset the timer is stopped, `pwm_o` is 0 and `wr_err_o` is 0.
- R2: Writing 1 to run (address 0, bit 0) while stopped presets the counter to 0xFFFFFFFE and clears the toggle. The first active level appears exactly 2 counter ticks after the write edge.
- R3: The active level lasts (compare − reload + 1) counter ticks. The compare register is at address 2 and the reload register at address 1.
- R4: The inactive level lasts (0xFFFFFFFF − compare) ticks, so one full period is (0xFFFFFFFF − reload + 1) ticks. On a wrap the counter takes the reload value.
- R5: With compare equal to reload, the active level lasts exactly one tick. The toggle flip-flop ignores a compare hit until the first wrap after a start, so compare = reload = 0xFFFFFFFE still produces 1 tick active and 1 tick inactive.
- R6: With the divider enable (address 0, bit 2) clear, the counter ticks on every clock. With it set, the counter ticks once every 2^(N+1) clocks, where N is address 0, bits 5:3.
- R7: The invert bit (address 0, bit 1) flips the pin level in both the running and the stopped state.
- R8: Writing 0 to run stops the counter and drives `pwm_o` to the inactive level (equal to the invert bit) in the cycle after the write. The pin holds that level until the next start.
- R9: A write to address 1 or 2 while running leaves the register unchanged and sets `wr_err_o`. The waveform keeps its old timing. The flag stays set until a write to address 3 clears it.
- R10: Writes to address 1 or 2 while stopped take effect and do not set `wr_err_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 reload, 2 compare, 3 error clear |
| wr_data_i | input | 32 | Write data |
| pwm_o | output | 1 | PWM output with polarity applied |
| wr_err_o | output | 1 | Sticky flag for a guarded write made while running |

## Verification
The waveform is measured at the pin for five setups, each as a start delay, an active run, an inactive run and a second active run. A wide setup with a short active part separates the reload term from the compare term in the period. A setup with compare equal to reload and the invert bit set checks the one-tick active time and the inverted level. Two divided setups (divide by 2 and by 8) scale every span and show whether the divider exponent is N+1 or N. The tightest legal setup, with both registers at 0xFFFFFFFE, exposes a compare hit acted on before the first wrap. Directed tests then check reset, a guarded write during a run with the period measured afterwards, clearing the flag, an unguarded write while stopped, and the stopped level held over many cycles.

// File: rtl/reload_pwm_pkg.sv
package reload_pwm_pkg;

    // register port geometry
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LOAD   = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_MATCH  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_ERRCLR = 2'd3;

    // control word bit positions
    localparam int unsigned CTRL_RUN  = 0;
    localparam int unsigned CTRL_INV  = 1;
    localparam int unsigned CTRL_PEN  = 2;
    localparam int unsigned CTRL_PSEL = 3;

endpackage

// File: rtl/rp_regs.sv
module rp_regs
    import reload_pwm_pkg::*;
#(
    parameter int unsigned CW = 32,
    parameter int unsigned PW = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CW-1:0]     wr_data_i,
    output logic              run_o,
    output logic              inv_o,
    output logic              pen_o,
    output logic [PW-1:0]     psel_o,
    output logic [CW-1:0]     load_o,
    output logic [CW-1:0]     match_o,
    output logic              err_o,
    output logic              start_o,
    output logic              stop_o
);

    typedef struct packed {
        logic          run;
        logic          inv;
        logic          pen;
        logic [PW-1:0] psel;
        logic [CW-1:0] load;
        logic [CW-1:0] match;
        logic          err;
    } regs_t;

    regs_t st_d, st_q;

    logic wr_ctrl, wr_load, wr_match, wr_clr;

    always_comb begin
        wr_ctrl  = wr_en_i && (wr_addr_i == ADDR_CTRL);
        wr_load  = wr_en_i && (wr_addr_i == ADDR_LOAD);
        wr_match = wr_en_i && (wr_addr_i == ADDR_MATCH);
        wr_clr   = wr_en_i && (wr_addr_i == ADDR_ERRCLR);

        st_d = st_q;

        if (wr_ctrl) begin
            st_d.run  = wr_data_i[CTRL_RUN];
            st_d.inv  = wr_data_i[CTRL_INV];
            st_d.pen  = wr_data_i[CTRL_PEN];
            st_d.psel = wr_data_i[CTRL_PSEL +: PW];
        end

        // reload and compare are guarded while the counter runs
        if (wr_load) begin
            if (st_q.run) st_d.err  = 1'b1;
            else          st_d.load = wr_data_i;
        end
        if (wr_match) begin
            if (st_q.run) st_d.err   = 1'b1;
            else          st_d.match = wr_data_i;
        end

        if (wr_clr) st_d.err = 1'b0;

        // edge pulses aligned with the control write
        start_o = wr_ctrl &&  wr_data_i[CTRL_RUN] && !st_q.run;
        stop_o  = wr_ctrl && !wr_data_i[CTRL_RUN] &&  st_q.run;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign run_o   = st_q.run;
    assign inv_o   = st_q.inv;
    assign pen_o   = st_q.pen;
    assign psel_o  = st_q.psel;
    assign load_o  = st_q.load;
    assign match_o = st_q.match;
    assign err_o   = st_q.err;

endmodule

// File: rtl/rp_prescale.sv
module rp_prescale #(
    parameter int unsigned PW = 3
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          start_i,
    input  logic          pen_i,
    input  logic [PW-1:0] psel_i,
    output logic          tick_o
);

    // largest division is 2^(2^PW); the divider counts up to that minus one
    localparam int unsigned DW = 1 << PW;

    typedef struct packed {
        logic [DW-1:0] div;
    } pre_t;

    pre_t st_d, st_q;

    logic [DW:0] term;
    logic        at_term;

    always_comb begin
        term    = ({{DW{1'b0}}, 1'b1} << ({{(32-PW){1'b0}}, psel_i} + 32'd1)) - 1'b1;
        // >= so a smaller divider chosen mid-run never has to wait for a wrap
        at_term = ({1'b0, st_q.div} >= term);
        tick_o  = run_i && (!pen_i || at_term);

        st_d = st_q;
        if (start_i) begin
            st_d.div = '0;
        end else if (run_i && pen_i) begin
            st_d.div = at_term ? '0 : st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

endmodule

// File: rtl/rp_core.sv
module rp_core #(
    parameter int unsigned CW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          run_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          tick_i,
    input  logic [CW-1:0] load_i,
    input  logic [CW-1:0] match_i,
    output logic [CW-1:0] cnt_o,
    output logic          tog_o
);

    localparam logic [CW-1:0] TOP    = '1;
    localparam logic [CW-1:0] PRESET = TOP - 1'b1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tog;
        logic          armed;
    } core_t;

    core_t st_d, st_q;

    logic wrap, hit;

    always_comb begin
        wrap = (st_q.cnt == TOP);
        // compare hits count only once the first reload has happened
        hit  = st_q.armed && (st_q.cnt == match_i);

        st_d = st_q;
        if (start_i) begin
            st_d.cnt   = PRESET;
            st_d.tog   = 1'b0;
            st_d.armed = 1'b0;
        end else if (stop_i) begin
            st_d.tog   = 1'b0;
        end else if (run_i && tick_i) begin
            if (wrap) begin
                st_d.cnt   = load_i;
                st_d.armed = 1'b1;
            end else begin
                st_d.cnt   = st_q.cnt + 1'b1;
            end
            st_d.tog = st_q.tog ^ wrap ^ hit;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
    assign tog_o = st_q.tog;

endmodule

// File: rtl/reload_pwm.sv
module reload_pwm
    import reload_pwm_pkg::*;
#(
    parameter int unsigned CW = 32,
    parameter int unsigned PW = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CW-1:0]     wr_data_i,
    output logic              pwm_o,
    output logic              wr_err_o
);

    logic          run_w, inv_w, pen_w, start_w, stop_w, tick_w, tog_w;
    logic [PW-1:0] psel_w;
    logic [CW-1:0] load_w, match_w, cnt_w;

    rp_regs #(.CW(CW), .PW(PW)) i_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .run_o     (run_w),
        .inv_o     (inv_w),
        .pen_o     (pen_w),
        .psel_o    (psel_w),
        .load_o    (load_w),
        .match_o   (match_w),
        .err_o     (wr_err_o),
        .start_o   (start_w),
        .stop_o    (stop_w)
    );

    rp_prescale #(.PW(PW)) i_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_w),
        .start_i (start_w),
        .pen_i   (pen_w),
        .psel_i  (psel_w),
        .tick_o  (tick_w)
    );

    rp_core #(.CW(CW)) i_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run_w),
        .start_i (start_w),
        .stop_i  (stop_w),
        .tick_i  (tick_w),
        .load_i  (load_w),
        .match_i (match_w),
        .cnt_o   (cnt_w),
        .tog_o   (tog_w)
    );

    // toggle is cleared on stop and start, so polarity alone sets the idle level
    assign pwm_o = tog_w ^ inv_w;

endmodule

// File: rtl/reload_pwm_chk.sv
module reload_pwm_chk
    import reload_pwm_pkg::*;
#(
    parameter int unsigned CW = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic              run_w,
    input logic              inv_w,
    input logic              pen_w,
    input logic              stop_w,
    input logic              tick_w,
    input logic              tog_w,
    input logic [CW-1:0]     load_w,
    input logic [CW-1:0]     cnt_w,
    input logic              pwm_o,
    input logic              wr_err_o
);

    localparam logic [CW-1:0] TOP = '1;

    p_start_preset_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(run_w) |-> (cnt_w == TOP - 1'b1));

    p_hold_between_ticks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && !tick_w && !stop_w) |=> $stable(tog_w));

    p_reload_on_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && tick_w && !stop_w && cnt_w == TOP) |=> (cnt_w == $past(load_w)));

    p_undivided_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && !pen_w) |-> tick_w);

    p_idle_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_w |-> (pwm_o == inv_w));

    p_guarded_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_w && wr_en_i && wr_addr_i == ADDR_LOAD) |=> ($stable(load_w) && wr_err_o));

    p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_err_o && !(wr_en_i && wr_addr_i == ADDR_ERRCLR)) |=> wr_err_o);

endmodule

bind reload_pwm reload_pwm_chk #(.CW(CW)) i_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .run_w     (run_w),
    .inv_w     (inv_w),
    .pen_w     (pen_w),
    .stop_w    (stop_w),
    .tick_w    (tick_w),
    .tog_w     (tog_w),
    .load_w    (load_w),
    .cnt_w     (cnt_w),
    .pwm_o     (pwm_o),
    .wr_err_o  (wr_err_o)
);

// File: tb/test_reload_pwm.sv
`timescale 1ns/1ps
module test_reload_pwm;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        pwm, err;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    reload_pwm i_reload_pwm (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .pwm_o     (pwm),
        .wr_err_o  (err)
    );

    // vector table: reload, compare, divider enable, divider exponent field, invert
    localparam int NV = 5;
    localparam logic [31:0] V_LOAD  [NV] = '{32'hFFFF_FFF0, 32'hFFFF_FFF8, 32'hFFFF_FFFA,
                                             32'hFFFF_FFFC, 32'hFFFF_FFFE};
    localparam logic [31:0] V_MATCH [NV] = '{32'hFFFF_FFF3, 32'hFFFF_FFF8, 32'hFFFF_FFFC,
                                             32'hFFFF_FFFD, 32'hFFFF_FFFE};
    localparam logic        V_PEN   [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [2:0]  V_PSEL  [NV] = '{3'd0, 3'd0, 3'd0, 3'd2, 3'd0};
    localparam logic        V_INV   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    function automatic logic [31:0] ctl(input logic run, input logic inv,
                                        input logic pen, input logic [2:0] n);
        return {26'd0, n, pen, inv, run};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // number of clocks the pin stays at lvl, sampled on falling edges
    task automatic span(input logic lvl, output int n);
        n = 0;
        while (pwm === lvl && n < 4000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, d, bad;
        logic inact;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset pwm", int'(pwm), 0);
        check("R1 reset err", int'(err), 0);

        // table walk: start delay, active, inactive, second active
        for (int v = 0; v < NV; v++) begin
            d     = V_PEN[v] ? (1 << (V_PSEL[v] + 1)) : 1;
            inact = V_INV[v];
            wr(2'd0, ctl(1'b0, inact, V_PEN[v], V_PSEL[v]));
            check($sformatf("R7 idle level v%0d", v), int'(pwm), int'(inact));
            wr(2'd1, V_LOAD[v]);
            wr(2'd2, V_MATCH[v]);
            check($sformatf("R10 no err v%0d", v), int'(err), 0);
            wr(2'd0, ctl(1'b1, inact, V_PEN[v], V_PSEL[v]));
            span(inact, n);
            check($sformatf("R2 R6 start delay v%0d", v), n, 2 * d);
            span(~inact, n);
            check($sformatf("R3 R5 R6 active v%0d", v), n, int'(V_MATCH[v] - V_LOAD[v] + 1) * d);
            span(inact, n);
            check($sformatf("R4 inactive v%0d", v), n, int'(32'hFFFF_FFFF - V_MATCH[v]) * d);
            span(~inact, n);
            check($sformatf("R3 R7 second active v%0d", v), n, int'(V_MATCH[v] - V_LOAD[v] + 1) * d);
        end
        wr(2'd0, ctl(1'b0, 1'b0, 1'b0, 3'd0));

        // guarded write while running (vector 0 timing, period 16)
        wr(2'd1, 32'hFFFF_FFF0);
        wr(2'd2, 32'hFFFF_FFF3);
        wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 3'd0));
        repeat (5) @(negedge clk);
        wr(2'd1, 32'hFFFF_FF00);
        wr(2'd2, 32'hFFFF_FF80);
        check("R9 err set", int'(err), 1);
        span(1'b1, n);
        span(1'b0, n);
        span(1'b1, n);
        check("R9 active unchanged", n, 4);
        span(1'b0, n);
        check("R9 inactive unchanged", n, 12);
        check("R9 err sticky", int'(err), 1);
        wr(2'd3, 32'd0);
        check("R9 err cleared", int'(err), 0);

        // stop during the active phase with inversion: pin must go and stay idle
        wr(2'd0, ctl(1'b1, 1'b1, 1'b0, 3'd0));
        span(1'b1, n);
        check("R8 stop from active", int'(pwm), 0);
        wr(2'd0, ctl(1'b0, 1'b1, 1'b0, 3'd0));
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            if (pwm !== 1'b1) bad++;
            @(negedge clk);
        end
        check("R8 idle hold", bad, 0);

        // stopped writes are accepted and raise no error
        wr(2'd1, 32'hFFFF_FFF8);
        wr(2'd2, 32'hFFFF_FFF9);
        check("R10 stopped write no err", int'(err), 0);
        wr(2'd0, ctl(1'b1, 1'b0, 1'b0, 3'd0));
        span(1'b0, n);
        span(1'b1, n);
        check("R10 new compare used", n, 2);
        span(1'b0, n);
        check("R10 new reload used", n, 6);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule